// File: doc/BRIEF.md
# Startup Identity and Mode Selector

This block runs once after each reset and decides how the device presents itself to the host. It reads the level of the drive-reset strap pin once, waits for the EEPROM probe step to report completion, and then picks an operating mode together with the identity words (vendor ID, product ID, device release) that the enumeration logic will report.

The identity comes from the first usable source. An attached EEPROM wins. Without one, the one-time-programmed (fused) bank is used, unless every word of that bank reads zero. A blank bank is not a usable identity, so the block falls back to built-in default values and signals a manufacturing-default mode. A strap pin held low at power-up overrides the mode and selects a board test mode, in which the mass-storage drive interface stays disabled.

When the choice is made, the block captures it in registers, raises a one-cycle valid strobe and holds the result until the next reset. The identity bank is `NUM_ID_WORDS` words of `ID_W` bits. Word k sits at bits [k*ID_W +: ID_W], with word 0 the vendor ID, word 1 the product ID and word 2 the release.

Top module: `boot_identity_select`

## Requirements
- R1: While reset is asserted, and after reset until the valid strobe, `id_valid`, `drive_en`, `mode` and `id_out` are all zero.
- R2: The strap pin is sampled only on the first rising clock edge after reset is released. Later changes of the pin have no effect on the mode.
- R3: A strap pin sampled low selects mode 2'b01 (board test), regardless of the EEPROM and fused-bank inputs.
- R4: `drive_en` is 1 only when the presented mode is 2'b00 (normal). In modes 2'b01 and 2'b10 it stays 0.
- R5: With the strap high and `eeprom_present` = 1, the mode is 2'b00 and `id_out` equals `eeprom_id`.
- R6: With the strap high, no EEPROM and at least one nonzero bit anywhere in `fuse_id`, the mode is 2'b00 and `id_out` equals `fuse_id`.
- R7: With the strap high, no EEPROM and `fuse_id` all zero, the mode is 2'b10 (manufacturing default) and `id_out` equals `DEFAULT_ID`. By default that is vendor 0x04B4, product 0x6830 and release 0x0001.
- R8: In board test mode, `id_out` follows the same source order as the other modes: EEPROM, then a nonblank fused bank, then `DEFAULT_ID`.
- R9: `id_valid` is high for exactly one cycle. It rises one clock after the first rising edge, following the strap sample, at which `probe_done` is 1. It is never high before that.
- R10: After the strobe, `mode`, `id_out` and `drive_en` hold their values and `id_valid` stays low until the next reset, whatever the inputs do.
- R11: `mode` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_rst_strap | input | 1 | Level of the drive-reset pin; low at power-up selects board test |
| probe_done | input | 1 | EEPROM probe has finished and all identity inputs are settled |
| eeprom_present | input | 1 | Probe found an EEPROM |
| eeprom_id | input | NUM_ID_WORDS*ID_W | Identity words read from the EEPROM |
| fuse_id | input | NUM_ID_WORDS*ID_W | Identity words from the one-time-programmed bank |
| mode | output | 2 | 00 normal, 01 board test, 10 manufacturing default |
| id_out | output | NUM_ID_WORDS*ID_W | Selected identity words |
| id_valid | output | 1 | One-cycle strobe when mode and identity are final |
| drive_en | output | 1 | Enable for the mass-storage drive interface |

## Verification
The embedded properties check several rules on every cycle: the mode is never 2'b11, `drive_en` never appears outside normal mode, the manufacturing mode always carries the default identity, the strobe lasts one cycle and follows `probe_done`, and the captured outputs stay frozen once the strobe has passed. The property on the strap latch also checks that the latched strap level stays fixed after the first sample. The source priority itself, which of EEPROM, fused bank or default wins, can be shown only by the bench scenarios. The same holds for the exact cycle of the strobe against a delayed probe, and for the strap being immune to a pin change right after its sample. The bench compares every run with values computed from its own model of the priority rules.

// File: rtl/bis_pkg.sv
package bis_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL      = 2'b00,
      MODE_BOARD_TEST  = 2'b01,
      MODE_MFG_DEFAULT = 2'b10
   } boot_mode_e;

   typedef enum logic {
      PH_WAIT = 1'b0,
      PH_HOLD = 1'b1
   } boot_phase_e;
endpackage

// File: rtl/bis_strap_sampler.sv
module bis_strap_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_pin,
   output logic strap_low,
   output logic sampled
);
   logic taken_q;
   logic low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         low_q   <= 1'b0;
      end else if (!taken_q) begin
         taken_q <= 1'b1;
         low_q   <= ~strap_pin;
      end
   end

   assign strap_low = low_q;
   assign sampled   = taken_q;

   // R2: the latched strap level never moves once taken
   p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      taken_q |=> $stable(low_q));
endmodule

// File: rtl/bis_id_arbiter.sv
module bis_id_arbiter
   import bis_pkg::*;
#(
   parameter int ID_W         = 16,
   parameter int NUM_ID_WORDS = 3,
   parameter logic [NUM_ID_WORDS*ID_W-1:0] DEFAULT_ID = '0
) (
   input  logic                          strap_low,
   input  logic                          eeprom_present,
   input  logic [NUM_ID_WORDS*ID_W-1:0]  eeprom_id,
   input  logic [NUM_ID_WORDS*ID_W-1:0]  fuse_id,
   output logic [1:0]                    mode_sel,
   output logic [NUM_ID_WORDS*ID_W-1:0]  id_sel
);
   logic [NUM_ID_WORDS-1:0] word_live;
   logic                    fuse_blank;

   for (genvar k = 0; k < NUM_ID_WORDS; k++) begin : g_word
      assign word_live[k] = |fuse_id[k*ID_W +: ID_W];
   end
   assign fuse_blank = ~|word_live;

   always_comb begin
      if (eeprom_present)
         id_sel = eeprom_id;
      else if (!fuse_blank)
         id_sel = fuse_id;
      else
         id_sel = DEFAULT_ID;

      if (strap_low)
         mode_sel = MODE_BOARD_TEST;
      else if (eeprom_present || !fuse_blank)
         mode_sel = MODE_NORMAL;
      else
         mode_sel = MODE_MFG_DEFAULT;
   end
endmodule

// File: rtl/bis_result_reg.sv
module bis_result_reg
   import bis_pkg::*;
#(
   parameter int ID_W         = 16,
   parameter int NUM_ID_WORDS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sampled,
   input  logic                          probe_done,
   input  logic [1:0]                    mode_in,
   input  logic [NUM_ID_WORDS*ID_W-1:0]  id_in,
   output logic [1:0]                    mode_o,
   output logic [NUM_ID_WORDS*ID_W-1:0]  id_o,
   output logic                          valid_o,
   output logic                          drive_o
);
   boot_phase_e                  phase_q;
   logic [1:0]                   mode_q;
   logic [NUM_ID_WORDS*ID_W-1:0] id_q;
   logic                         valid_q;
   logic                         drive_q;
   logic                         capture;

   assign capture = (phase_q == PH_WAIT) && sampled && probe_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WAIT;
         mode_q  <= 2'b00;
         id_q    <= '0;
         valid_q <= 1'b0;
         drive_q <= 1'b0;
      end else begin
         valid_q <= capture;
         if (capture) begin
            phase_q <= PH_HOLD;
            mode_q  <= mode_in;
            id_q    <= id_in;
            drive_q <= (mode_in == MODE_NORMAL);
         end
      end
   end

   assign mode_o  = mode_q;
   assign id_o    = id_q;
   assign valid_o = valid_q;
   assign drive_o = drive_q;

   // R1: nothing is presented before the capture
   p_quiet_before_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WAIT) |-> (mode_q == 2'b00 && id_q == '0 && !drive_q && !valid_q));
   // R10: captured values stay frozen after the strobe
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD && !valid_q) |-> ($stable(mode_q) && $stable(id_q) && $stable(drive_q)));
endmodule

// File: rtl/boot_identity_select.sv
module boot_identity_select
   import bis_pkg::*;
#(
   parameter int ID_W         = 16,
   parameter int NUM_ID_WORDS = 3,
   parameter logic [NUM_ID_WORDS*ID_W-1:0] DEFAULT_ID = 48'h0001_6830_04B4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          drv_rst_strap,
   input  logic                          probe_done,
   input  logic                          eeprom_present,
   input  logic [NUM_ID_WORDS*ID_W-1:0]  eeprom_id,
   input  logic [NUM_ID_WORDS*ID_W-1:0]  fuse_id,
   output logic [1:0]                    mode,
   output logic [NUM_ID_WORDS*ID_W-1:0]  id_out,
   output logic                          id_valid,
   output logic                          drive_en
);
   localparam int BANK_W = NUM_ID_WORDS * ID_W;

   if (ID_W < 8) begin : g_chk_width
      $error("boot_identity_select: ID_W must be at least 8");
   end
   if (NUM_ID_WORDS < 2) begin : g_chk_words
      $error("boot_identity_select: NUM_ID_WORDS must be at least 2");
   end
   if (DEFAULT_ID == '0) begin : g_chk_default
      $error("boot_identity_select: DEFAULT_ID must not be blank");
   end

   logic              strap_low;
   logic              sampled;
   logic [1:0]        mode_sel;
   logic [BANK_W-1:0] id_sel;

   bis_strap_sampler u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_pin (drv_rst_strap),
      .strap_low (strap_low),
      .sampled   (sampled)
   );

   bis_id_arbiter #(
      .ID_W         (ID_W),
      .NUM_ID_WORDS (NUM_ID_WORDS),
      .DEFAULT_ID   (DEFAULT_ID)
   ) u_arb (
      .strap_low      (strap_low),
      .eeprom_present (eeprom_present),
      .eeprom_id      (eeprom_id),
      .fuse_id        (fuse_id),
      .mode_sel       (mode_sel),
      .id_sel         (id_sel)
   );

   bis_result_reg #(
      .ID_W         (ID_W),
      .NUM_ID_WORDS (NUM_ID_WORDS)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .sampled    (sampled),
      .probe_done (probe_done),
      .mode_in    (mode_sel),
      .id_in      (id_sel),
      .mode_o     (mode),
      .id_o       (id_out),
      .valid_o    (id_valid),
      .drive_o    (drive_en)
   );

   // R11: the unused mode code never appears
   p_mode_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);
   // R4: drive interface enabled only in normal mode
   p_drive_normal_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> (mode == MODE_NORMAL));
   // R7: manufacturing mode always carries the default identity
   p_mfg_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_MFG_DEFAULT) |-> (id_out == DEFAULT_ID));
   // R9: single-cycle strobe
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |=> !id_valid);
   // R9: strobe only after probe completion
   p_after_probe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> $past(probe_done));
endmodule

// File: tb/tb_boot_identity_select.sv
`timescale 1ns/1ps
module tb_boot_identity_select;
   localparam int W = 48;
   localparam logic [W-1:0] DEF_ID = 48'h0001_6830_04B4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         drv_rst_strap = 1'b1;
   logic         probe_done = 1'b0;
   logic         eeprom_present = 1'b0;
   logic [W-1:0] eeprom_id = '0;
   logic [W-1:0] fuse_id = '0;
   logic [1:0]   mode;
   logic [W-1:0] id_out;
   logic         id_valid;
   logic         drive_en;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   boot_identity_select dut (
      .clk(clk), .rst_n(rst_n), .drv_rst_strap(drv_rst_strap),
      .probe_done(probe_done), .eeprom_present(eeprom_present),
      .eeprom_id(eeprom_id), .fuse_id(fuse_id), .mode(mode),
      .id_out(id_out), .id_valid(id_valid), .drive_en(drive_en)
   );

   function automatic logic [1:0] exp_mode(bit strap_lvl, bit eep, logic [W-1:0] fu);
      if (!strap_lvl) return 2'b01;
      if (eep || fu != '0) return 2'b00;
      return 2'b10;
   endfunction

   function automatic logic [W-1:0] exp_id(bit eep, logic [W-1:0] ee, logic [W-1:0] fu);
      if (eep) return ee;
      if (fu != '0) return fu;
      return DEF_ID;
   endfunction

   task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_boot(bit strap_lvl, bit flip, bit eep, logic [W-1:0] ee,
                           logic [W-1:0] fu, int pdelay);
      logic [1:0]   em;
      logic [W-1:0] ei;
      string        tag;
      em = exp_mode(strap_lvl, eep, fu);
      ei = exp_id(eep, ee, fu);
      if (!strap_lvl)   tag = "R3/R8";
      else if (eep)     tag = "R5";
      else if (fu != 0) tag = "R6";
      else              tag = "R7";

      @(negedge clk);
      rst_n = 1'b0; probe_done = 1'b0; drv_rst_strap = strap_lvl;
      eeprom_present = eep; eeprom_id = ee; fuse_id = fu;
      repeat (2) @(negedge clk);
      check(!id_valid && !drive_en && mode == 2'b00 && id_out == '0, "R1 reset outputs",
            {id_valid, drive_en, mode, id_out[W-5:0]}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      if (flip) drv_rst_strap = ~strap_lvl;
      for (int i = 0; i < pdelay; i++) begin
         check(!id_valid && mode == 2'b00 && id_out == '0, "R1/R9 quiet before probe",
               {id_valid, mode}, '0);
         @(negedge clk);
      end
      probe_done = 1'b1;
      @(negedge clk);
      check(id_valid == 1'b1, "R9 strobe one clock after probe", id_valid, 1);
      check(mode == em, {tag, " mode"}, mode, em);
      if (flip) check(mode == em, "R2 strap change after sample ignored", mode, em);
      check(id_out == ei, {tag, " identity"}, id_out, ei);
      check(drive_en == (em == 2'b00), "R4 drive enable", drive_en, (em == 2'b00));
      check(mode != 2'b11, "R11 legal mode", mode, em);
      @(negedge clk);
      check(id_valid == 1'b0, "R9 strobe single cycle", id_valid, 0);
      eeprom_present = ~eep; eeprom_id = ~ee; fuse_id = '0;
      drv_rst_strap = ~drv_rst_strap; probe_done = 1'b0;
      repeat (2) @(negedge clk);
      probe_done = 1'b1;
      repeat (2) @(negedge clk);
      check(!id_valid && mode == em && id_out == ei && drive_en == (em == 2'b00),
            "R10 outputs held", {id_valid, mode, id_out[W-4:0]}, {1'b0, em, ei[W-4:0]});
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] ee;
      logic [W-1:0] fu;
      int           sel;
      void'($urandom(32'd2024));
      // directed corners
      run_boot(1, 0, 1, 48'h0100_1234_abcd, 48'h0002_5555_0777, 0); // R5
      run_boot(1, 0, 0, 48'h0100_1234_abcd, 48'h0002_5555_0777, 1); // R6
      run_boot(1, 0, 0, 48'h0, 48'h0000_0000_0000, 2);              // R7 blank bank
      run_boot(1, 0, 0, 48'h0, 48'h0001_0000_0000, 0);              // R6 one word nonzero
      run_boot(1, 0, 0, 48'h0, 48'h0000_0000_0001, 3);              // R6 lowest bit
      run_boot(0, 0, 1, 48'h0100_1234_abcd, 48'h0, 0);              // R3/R8 eeprom
      run_boot(0, 0, 0, 48'h0, 48'h0, 1);                           // R3/R8 default id
      run_boot(0, 0, 0, 48'h0, 48'h0003_4444_0999, 2);              // R3/R8 fuse id
      run_boot(1, 1, 0, 48'h0, 48'h0, 2);                           // R2 high then low
      run_boot(0, 1, 1, 48'h0100_1234_abcd, 48'h0, 4);              // R2 low then high
      run_boot(1, 0, 1, 48'h0, 48'h0, 8);                           // R5 blank eeprom words
      // random runs
      for (int n = 0; n < 40; n++) begin
         ee = {$urandom(), $urandom()};
         sel = $urandom_range(0, 3);
         if (sel == 0)      fu = '0;
         else if (sel == 1) fu = W'(64'd1 << $urandom_range(0, W - 1));
         else               fu = {$urandom(), $urandom()};
         run_boot(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                  bit'($urandom_range(0, 1)), ee, fu, $urandom_range(0, 5));
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule